// File: doc/BRIEF.md
# Posted-Write Register Synchronizer

This block sits between a fast interface clock, where a requester reads and writes a timer's registers, and a slow functional clock, where the timer itself runs. Ten of the timer's registers live in the functional domain. A write to any of them is held in a bus-side buffer and carried across with its own toggle request and toggle acknowledge. Each of these registers has a pending bit, and the bit stays set for the whole time its transfer is in flight.

Two write policies are offered, chosen by bit 2 of the interface-control register. In posted mode, the reset default, a write to a synchronized register completes in its first cycle and the requester can go on working while the value crosses. The requester is expected to poll the pending-status register before it touches that register again. A write that lands on a pending register is dropped and flagged, and so is a read of a pending register. In non-posted mode the bridge stalls the requester until the transfer has landed, so no polling is needed but every write costs the full crossing time. The load and trigger registers are also kept in order: a trigger never reaches the functional domain ahead of a load that was written before it.

The remaining registers (identification, configuration, the two status words, interrupt enable, wake enable, the two capture words, interface control and the pending-status word) are served in the interface domain. They never stall and never set a pending bit.

Top module: `psw_bridge`

## Requirements
- R1: After reset the pending-status register (offset 0x34) reads 0, the interface-control register (offset 0x40) reads 0x4 (bit 2 set = posted mode), the identification register (offset 0x00) reads the ID_VALUE parameter, req_ready is high while idle, and rsp_valid and f_stb are low.
- R2: In posted mode, a write to a synchronized register completes with req_ready high in its first cycle. It sets that register's pending bit, which an immediately following read of 0x34 shows. Bit positions: 0x24 → bit 0, 0x28 → bit 1, 0x2c (load) → bit 2, 0x30 (trigger) → bit 3, 0x38 → bit 4, 0x48 → bit 5, 0x4c → bit 6, 0x50 → bit 7, 0x54 → bit 8, 0x58 → bit 9.
- R3: Each accepted write is delivered once to the functional domain: the channel's f_stb bit pulses and its slice f_data[i*32 +: 32] carries the written value. The pending bit then clears, within 40 interface cycles at the bench's clock ratio, and a read of that register returns the written value without error.
- R4: A write to a synchronized register whose pending bit is set is dropped. It raises rsp_err, and the value changes neither the read-back nor the functional-domain copy.
- R5: In posted mode, a read of a synchronized register whose pending bit is set completes without stall and raises rsp_err.
- R6: Writes to non-synchronized registers (for example configuration at 0x10) set no pending bit, raise no error, never stall, and read back at once.
- R7: With bit 2 of 0x40 cleared, a write to a synchronized register holds req_ready low until its transfer has landed. When the write completes, its pending bit is already clear and the functional strobe has already happened.
- R8: With bit 2 of 0x40 cleared, a read of a synchronized register that is still pending stalls until the bit clears. It then returns the written value with no error.
- R9: A trigger write (0x30) accepted while a load write (0x2c) is pending reaches the functional domain strictly after the load.
- R10: rsp_valid is high for exactly the one cycle after each completed access. rsp_err is only ever high together with rsp_valid.
- R11: Each f_stb bit is high for a single functional-clock cycle per delivered write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset, interface domain |
| req_valid | input | 1 | Access request, held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | DW (32) | Write data |
| req_ready | output | 1 | Access completes in this cycle when high with req_valid |
| rsp_valid | output | 1 | Response of the access completed in the previous cycle |
| rsp_rdata | output | DW (32) | Read data (0 for writes) |
| rsp_err | output | 1 | Dropped write or read of a pending register |
| fclk | input | 1 | Functional clock |
| frst | input | 1 | Synchronous active-high reset, functional domain |
| f_stb | output | 10 | Per-register delivery strobe, functional domain |
| f_data | output | 10*DW (320) | Per-register delivered values, register i in slice i*DW |

## Verification
The bench writes a register and then, before the crossing can possibly finish, writes it again and reads it. A bridge that does not drop the second write would deliver 0x9999 or leave two strobes on the functional side, and one that does not flag the early read would return rsp_err low. It writes load and then trigger back to back and compares the functional-clock cycles in which the two strobes arrive; a bridge that launches both at once would show equal or reversed stamps. In non-posted mode it measures the stall length and checks that the strobe has already landed when the write returns, which catches a bridge that releases req_ready early. It also leaves a posted write in flight, switches modes, and reads that register, which catches a bridge that flags the read instead of waiting for it.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int NUM_SYNC = 10;
  localparam int IDX_W    = $clog2(NUM_SYNC);
  localparam int AW       = 8;
  localparam int SLOT_LOAD = 2;
  localparam int SLOT_TRIG = 3;
  localparam int POSTED_BIT = 2;

  // locally served registers
  localparam logic [AW-1:0] A_ID    = 8'h00;
  localparam logic [AW-1:0] A_CFG   = 8'h10;
  localparam logic [AW-1:0] A_SYSST = 8'h14;
  localparam logic [AW-1:0] A_IRQST = 8'h18;
  localparam logic [AW-1:0] A_IRQEN = 8'h1c;
  localparam logic [AW-1:0] A_WAKE  = 8'h20;
  localparam logic [AW-1:0] A_PEND  = 8'h34;
  localparam logic [AW-1:0] A_CAP   = 8'h3c;
  localparam logic [AW-1:0] A_IFC   = 8'h40;
  localparam logic [AW-1:0] A_CAP2  = 8'h44;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } slot_t;

  // map an offset onto its synchronized channel (pending bit position)
  function automatic slot_t slot_of(input logic [AW-1:0] a);
    slot_t s;
    s.hit = 1'b1;
    case (a)
      8'h24:   s.idx = IDX_W'(0);
      8'h28:   s.idx = IDX_W'(1);
      8'h2c:   s.idx = IDX_W'(2);
      8'h30:   s.idx = IDX_W'(3);
      8'h38:   s.idx = IDX_W'(4);
      8'h48:   s.idx = IDX_W'(5);
      8'h4c:   s.idx = IDX_W'(6);
      8'h50:   s.idx = IDX_W'(7);
      8'h54:   s.idx = IDX_W'(8);
      8'h58:   s.idx = IDX_W'(9);
      default: begin s.hit = 1'b0; s.idx = '0; end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/psw_sync2.sv
module psw_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/psw_chan_src.sv
module psw_chan_src #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [DW-1:0] wdata,
  input  logic          launch_ok,
  input  logic          ack_q,
  output logic          pend,
  output logic          req_tgl,
  output logic [DW-1:0] hold
);
  logic waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      waiting <= 1'b0;
      req_tgl <= 1'b0;
      hold    <= '0;
    end else if (accept) begin
      hold <= wdata;
      pend <= 1'b1;
      if (launch_ok) req_tgl <= ~req_tgl;
      else           waiting <= 1'b1;
    end else if (waiting && launch_ok) begin
      req_tgl <= ~req_tgl;
      waiting <= 1'b0;
    end else if (pend && !waiting && (ack_q == req_tgl)) begin
      pend <= 1'b0;
    end
  end

  assert_accept_idle_R4: assert property (@(posedge clk) disable iff (rst)
    accept |-> !pend);
  assert_pend_from_accept_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(accept));
  assert_clear_on_ack_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(pend) |-> (ack_q == req_tgl));
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (pend && $past(pend)) |-> $stable(hold));
endmodule

// File: rtl/psw_chan_dst.sv
module psw_chan_dst #(
  parameter int DW = 32
) (
  input  logic          fclk,
  input  logic          frst,
  input  logic          req_q,
  input  logic [DW-1:0] hold,
  output logic          ack,
  output logic          stb,
  output logic [DW-1:0] data
);
  logic seen;

  always_ff @(posedge fclk) begin
    if (frst) begin
      seen <= 1'b0;
      stb  <= 1'b0;
      data <= '0;
    end else begin
      seen <= req_q;
      stb  <= req_q ^ seen;
      if (req_q ^ seen) data <= hold;
    end
  end

  assign ack = seen;

  assert_stb_single_R11: assert property (@(posedge fclk) disable iff (frst)
    stb |=> !stb);
endmodule

// File: rtl/psw_bus_ctl.sv
module psw_bus_ctl
  import psw_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [DW-1:0] ID_VALUE = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [AW-1:0]          req_addr,
  input  logic [DW-1:0]          req_wdata,
  output logic                   req_ready,
  output logic                   rsp_valid,
  output logic [DW-1:0]          rsp_rdata,
  output logic                   rsp_err,
  input  logic [NUM_SYNC-1:0]    pend,
  input  logic [NUM_SYNC*DW-1:0] hold,
  output logic [NUM_SYNC-1:0]    accept
);
  localparam logic [DW-1:0] IFC_RESET = DW'(1) << POSTED_BIT;

  slot_t         sl;
  logic          tgt_pend;
  logic          posted;
  logic          take, drop, rd_err, hs;
  logic          np_hold;
  logic [DW-1:0] cfg, irq_en, wake, ifc;
  logic [DW-1:0] rd_mux;

  assign sl       = slot_of(req_addr);
  assign tgt_pend = sl.hit && pend[sl.idx];
  assign posted   = ifc[POSTED_BIT];
  assign hs       = req_valid && req_ready;

  always_comb begin
    req_ready = 1'b1;
    take      = 1'b0;
    drop      = 1'b0;
    rd_err    = 1'b0;
    if (req_valid && sl.hit) begin
      if (np_hold) begin
        req_ready = !tgt_pend;
      end else if (posted) begin
        if (req_write) begin
          if (tgt_pend) drop = 1'b1;
          else          take = 1'b1;
        end else if (tgt_pend) begin
          rd_err = 1'b1;
        end
      end else begin
        if (tgt_pend) begin
          req_ready = 1'b0;
        end else if (req_write) begin
          take      = 1'b1;
          req_ready = 1'b0;
        end
      end
    end
  end

  generate
    for (genvar i = 0; i < NUM_SYNC; i++) begin : g_acc
      assign accept[i] = take && (sl.idx == IDX_W'(i));
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (sl.hit) begin
      rd_mux = hold[sl.idx*DW +: DW];
    end else begin
      case (req_addr)
        A_ID:    rd_mux = ID_VALUE;
        A_CFG:   rd_mux = cfg;
        A_IRQEN: rd_mux = irq_en;
        A_WAKE:  rd_mux = wake;
        A_IFC:   rd_mux = ifc;
        A_PEND:  rd_mux = DW'(pend);
        A_SYSST, A_IRQST, A_CAP, A_CAP2: rd_mux = '0;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      np_hold   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      cfg       <= '0;
      irq_en    <= '0;
      wake      <= '0;
      ifc       <= IFC_RESET;
    end else begin
      rsp_valid <= hs;
      rsp_err   <= hs && (drop || rd_err);
      if (hs) rsp_rdata <= req_write ? '0 : rd_mux;
      if (take && !posted)  np_hold <= 1'b1;
      else if (np_hold && hs) np_hold <= 1'b0;
      if (hs && req_write && !sl.hit) begin
        case (req_addr)
          A_CFG:   cfg    <= req_wdata;
          A_IRQEN: irq_en <= req_wdata;
          A_WAKE:  wake   <= req_wdata;
          A_IFC:   ifc    <= req_wdata;
          default: ;
        endcase
      end
    end
  end

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready));
  assert_err_with_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid);
endmodule

// File: rtl/psw_bridge.sv
module psw_bridge
  import psw_pkg::*;
#(
  parameter int            DW       = 32,
  parameter logic [DW-1:0] ID_VALUE = DW'(32'h0051_7A01)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [AW-1:0]          req_addr,
  input  logic [DW-1:0]          req_wdata,
  output logic                   req_ready,
  output logic                   rsp_valid,
  output logic [DW-1:0]          rsp_rdata,
  output logic                   rsp_err,
  input  logic                   fclk,
  input  logic                   frst,
  output logic [NUM_SYNC-1:0]    f_stb,
  output logic [NUM_SYNC*DW-1:0] f_data
);
  logic [NUM_SYNC-1:0]    pend, accept, req_tgl, req_q, ack, ack_q;
  logic [NUM_SYNC*DW-1:0] hold;

  psw_bus_ctl #(.DW(DW), .ID_VALUE(ID_VALUE)) u_ctl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .pend(pend), .hold(hold), .accept(accept)
  );

  psw_sync2 #(.W(NUM_SYNC)) u_req_sync (
    .clk(fclk), .rst(frst), .d(req_tgl), .q(req_q)
  );

  psw_sync2 #(.W(NUM_SYNC)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack), .q(ack_q)
  );

  generate
    for (genvar i = 0; i < NUM_SYNC; i++) begin : g_ch
      logic launch_ok;
      if (i == SLOT_TRIG) begin : g_gate
        assign launch_ok = !pend[SLOT_LOAD];
      end else begin : g_free
        assign launch_ok = 1'b1;
      end

      psw_chan_src #(.DW(DW)) u_src (
        .clk(clk), .rst(rst), .accept(accept[i]),
        .wdata(req_wdata), .launch_ok(launch_ok), .ack_q(ack_q[i]),
        .pend(pend[i]), .req_tgl(req_tgl[i]), .hold(hold[i*DW +: DW])
      );

      psw_chan_dst #(.DW(DW)) u_dst (
        .fclk(fclk), .frst(frst), .req_q(req_q[i]),
        .hold(hold[i*DW +: DW]), .ack(ack[i]),
        .stb(f_stb[i]), .data(f_data[i*DW +: DW])
      );
    end
  endgenerate

  assert_trig_after_load_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(req_tgl[SLOT_TRIG]) != req_tgl[SLOT_TRIG]) |-> !$past(pend[SLOT_LOAD]));
endmodule

// File: tb/psw_bridge_bench.sv
module psw_bridge_bench;
  localparam int NS = 10;
  localparam logic [31:0] IDV = 32'h0051_7A01;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [31:0] mask;
    logic        exp_err;
    logic        settle;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h34, 32'h0,    32'h0,     32'hFFFFFFFF, 1'b0, 1'b0, 4'd1}, // R1 pending clear
    '{1'b0, 8'h40, 32'h0,    32'h4,     32'hFFFFFFFF, 1'b0, 1'b0, 4'd1}, // R1 posted default
    '{1'b0, 8'h00, 32'h0,    IDV,       32'hFFFFFFFF, 1'b0, 1'b0, 4'd1}, // R1 id
    '{1'b1, 8'h28, 32'h1234, 32'h0,     32'h0,        1'b0, 1'b0, 4'd2}, // R2 posted write
    '{1'b0, 8'h34, 32'h0,    32'h2,     32'hFFFFFFFF, 1'b0, 1'b0, 4'd2}, // R2 bit 1 set
    '{1'b1, 8'h28, 32'h9999, 32'h0,     32'h0,        1'b1, 1'b0, 4'd4}, // R4 dropped
    '{1'b0, 8'h28, 32'h0,    32'h0,     32'h0,        1'b1, 1'b0, 4'd5}, // R5 early read
    '{1'b0, 8'h34, 32'h0,    32'h0,     32'hFFFFFFFF, 1'b0, 1'b1, 4'd3}, // R3 cleared
    '{1'b0, 8'h28, 32'h0,    32'h1234,  32'hFFFFFFFF, 1'b0, 1'b0, 4'd4}, // R4 old value kept
    '{1'b1, 8'h10, 32'h55,   32'h0,     32'h0,        1'b0, 1'b0, 4'd6}, // R6 local write
    '{1'b0, 8'h34, 32'h0,    32'h0,     32'hFFFFFFFF, 1'b0, 1'b0, 4'd6}, // R6 no pending
    '{1'b0, 8'h10, 32'h0,    32'h55,    32'hFFFFFFFF, 1'b0, 1'b0, 4'd6}, // R6 read back
    '{1'b1, 8'h58, 32'hABC,  32'h0,     32'h0,        1'b0, 1'b0, 4'd2}, // R2 last channel
    '{1'b0, 8'h34, 32'h0,    32'h200,   32'hFFFFFFFF, 1'b0, 1'b0, 4'd2}, // R2 bit 9 set
    '{1'b0, 8'h58, 32'h0,    32'hABC,   32'hFFFFFFFF, 1'b0, 1'b1, 4'd3}  // R3 settled read
  };

  logic clk = 1'b0, fclk = 1'b0;
  logic rst, frst;
  logic req_valid, req_write;
  logic [7:0] req_addr;
  logic [31:0] req_wdata;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NS-1:0] f_stb;
  logic [NS*32-1:0] f_data;

  int checks = 0, fails = 0;
  bit done = 0;
  int fcyc = 0;
  int scount [NS];
  logic [31:0] sdata [NS];
  int sstamp [NS];
  logic [NS-1:0] stb_prev = '0;
  bit dbl = 0;

  always #4 clk = ~clk;
  always #20 fclk = ~fclk;

  psw_bridge u_psw_bridge (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .fclk(fclk), .frst(frst), .f_stb(f_stb), .f_data(f_data)
  );

  always @(negedge fclk) begin
    fcyc++;
    for (int i = 0; i < NS; i++) begin
      if (f_stb[i]) begin
        scount[i]++;
        sdata[i]  = f_data[i*32 +: 32];
        sstamp[i] = fcyc;
        if (stb_prev[i]) dbl = 1;
      end
    end
    stb_prev = f_stb;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic err, output int stalls);
    @(negedge clk);
    chk(!rsp_valid && !rsp_err, "R10 response idle between accesses", {30'b0, rsp_valid, rsp_err}, 32'h0);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    stalls = 0;
    #1;
    while (!req_ready && stalls < 2000) begin
      @(negedge clk); #1;
      stalls++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; err = rsp_err;
    chk(rsp_valid, "R10 rsp_valid after handshake", {31'b0, rsp_valid}, 32'h1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic err;
    int st;
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    rst = 1; frst = 1;
    repeat (4) @(negedge fclk);
    rst = 0; frst = 0;
    @(negedge clk);
    chk(!rsp_valid && f_stb == '0 && req_ready, "R1 reset outputs",
        {21'b0, f_stb, rsp_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].settle) repeat (40) @(negedge clk);
      access(VECS[i].wr, VECS[i].addr, VECS[i].data, rd, err, st);
      chk((err == VECS[i].exp_err) && ((rd & VECS[i].mask) == (VECS[i].exp & VECS[i].mask)) && (st == 0),
          $sformatf("R%0d vector %0d data/err/stall", VECS[i].req, i), rd, VECS[i].exp);
      if (err != VECS[i].exp_err)
        chk(0, $sformatf("R%0d vector %0d err", VECS[i].req, i), {31'b0, err}, {31'b0, VECS[i].exp_err});
    end

    // R4 / R11: functional side saw only the first counter write
    chk(scount[1] == 1, "R4 counter strobe count", scount[1], 1);
    chk(sdata[1] == 32'h1234, "R4 counter delivered value", sdata[1], 32'h1234);
    chk(scount[9] == 1 && sdata[9] == 32'hABC, "R3 channel 9 delivered", sdata[9], 32'hABC);

    // R9: load then trigger back to back
    access(1'b1, 8'h2c, 32'h100, rd, err, st);
    access(1'b1, 8'h30, 32'h1, rd, err, st);
    chk(err == 0 && st == 0, "R9 trigger accepted posted", {31'b0, err}, 32'h0);
    access(1'b0, 8'h34, 32'h0, rd, err, st);
    chk(rd == 32'h0C, "R9 load and trigger pending", rd, 32'h0C);
    repeat (60) @(negedge clk);
    chk(scount[2] == 1 && scount[3] == 1, "R9 both delivered", scount[3], 1);
    chk(sstamp[2] < sstamp[3], "R9 trigger after load", sstamp[3], sstamp[2] + 1);
    chk(sdata[2] == 32'h100, "R9 load value", sdata[2], 32'h100);

    // R7: non-posted write stalls until delivered
    access(1'b1, 8'h40, 32'h0, rd, err, st);
    access(1'b1, 8'h38, 32'h77, rd, err, st);
    chk(st >= 5 && st <= 40 && err == 0, "R7 non-posted stall length", st, 5);
    chk(scount[4] == 1 && sdata[4] == 32'h77, "R7 delivered before completion", sdata[4], 32'h77);
    access(1'b0, 8'h34, 32'h0, rd, err, st);
    chk(rd == 32'h0, "R7 pending clear after completion", rd, 32'h0);

    // R8: posted write left in flight, then non-posted read waits for it
    access(1'b1, 8'h40, 32'h4, rd, err, st);
    access(1'b1, 8'h24, 32'h3, rd, err, st);
    access(1'b1, 8'h40, 32'h0, rd, err, st);
    chk(st == 0 && err == 0, "R6 interface control never stalls", st, 0);
    access(1'b0, 8'h24, 32'h0, rd, err, st);
    chk(st >= 1 && err == 0 && rd == 32'h3, "R8 non-posted read waits", rd, 32'h3);
    access(1'b1, 8'h40, 32'h4, rd, err, st);
    access(1'b0, 8'h40, 32'h0, rd, err, st);
    chk(rd == 32'h4, "R1 posted mode restored", rd, 32'h4);

    repeat (40) @(negedge clk);
    chk(!dbl, "R11 strobes single cycle", {31'b0, dbl}, 32'h0);
    chk(scount[0] == 1 && sdata[0] == 32'h3, "R3 control delivered", sdata[0], 32'h3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule